// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This unit computes clamped integer arithmetic for a datapath. An opcode selects one operation: signed or unsigned add and subtract at 32 or 64 bits, signed doubling, or clamping a value to a programmable number of bits. The clamp can act on a whole 32-bit word or on two 16-bit halves on their own. Every operation that has to clamp sets one shared sticky flag. The flag stays set until a clear input is pulsed. One further add opcode returns the plain wrapped sum and still sets the flag when signed overflow occurs.

Operands arrive as two 64-bit words together with a 5-bit width field and a valid strobe. Opcodes that work on 32 bits use only the low halves of the operands and return a zero-extended result. The result and an output strobe appear one clock after the input strobe. The result register keeps its value while no new operation is issued.

Top module: `sat_alu`

## Requirements
- R1: Opcode 1 (signed add, 32-bit): when both operands have the same sign and the sum's sign differs from operand A's sign, the result is 0x7FFFFFFF if A is non-negative and 0x80000000 if A is negative. Otherwise the result is the plain sum.
- R2: Opcode 2 (signed subtract, 32-bit): when the operand signs differ and the difference's sign differs from A's sign, the result clamps in the same way as R1. Otherwise the result is A-B.
- R3: Opcode 4 (unsigned add, 32-bit) returns 0xFFFFFFFF when the sum carries out. Opcode 5 (unsigned subtract, 32-bit) returns 0 when B exceeds A.
- R4: Opcode 3 (signed doubling of A): a signed A of 0x40000000 or above gives 0x7FFFFFFF. A signed A of 0xC0000000 or below gives 0x80000000. Reaching either limit counts as a clamp, including A equal to 0xC0000000. Any other A gives A shifted left by one.
- R5: Opcode 6 (signed clamp of A to width n, where n is sat_n): let t be A shifted right arithmetically by n. If t > 0 the result is (1<<n)-1. If t < -1 the result is the inverse of that mask. Otherwise the result is A.
- R6: Opcode 8 (unsigned clamp of A to width n): a negative A gives 0, and an A above (1<<n)-1 gives that mask. Otherwise the result is A.
- R7: Opcodes 7 and 9 apply R5 and R6 respectively to the sign-extended low half A[15:0] and the sign-extended high half A[31:16], each on its own. The two 16-bit results are packed with the low half in bits 15:0 and the high half in bits 31:16. A clamp in either half counts.
- R8: Opcode 0 returns the wrapped 32-bit sum. It counts as a clamp when the R1 overflow condition holds.
- R9: Opcodes 10 (signed add), 11 (unsigned add), 12 (signed subtract) and 13 (unsigned subtract) apply the rules of R1, R3 and R2 to the full 64-bit operands. The limits are 0x7FFF_FFFF_FFFF_FFFF, 0x8000_0000_0000_0000, all ones and zero.
- R10: sat_flag sets in the cycle after an accepted operation that clamps. It holds through operations that do not clamp. It clears in the cycle after clr_sticky is high, unless a clamp arrives in that same cycle, in which case the set wins.
- R11: result and out_valid update one clock after in_valid. out_valid is low when in_valid was low. result holds its value while in_valid is low. Reset (rst_n low, synchronous) clears result, out_valid and sat_flag.
- R12: Opcodes 14 and 15 return 0 and never count as a clamp. Opcodes that work on 32 bits return 0 in result[63:32] and ignore op_a[63:32] and op_b[63:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| opcode | input | 4 | Operation select |
| op_a | input | 64 | Operand A (the 32-bit ops use bits 31:0) |
| op_b | input | 64 | Operand B (the 32-bit ops use bits 31:0) |
| sat_n | input | 5 | Clamp width n for opcodes 6 to 9 |
| clr_sticky | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result is new this cycle |
| result | output | 64 | Registered result |
| sat_flag | output | 1 | Sticky clamp flag |

## Verification
The hardest situation to reach from the ports is a clamp and a flag clear arriving in the same cycle. The stimulus reaches it by issuing every table vector with clr_sticky held high. Each vector's flag therefore shows only its own clamp, and the set-over-clear priority is tested on every clamping entry. Other corners that are easy to miss are also targeted directly: a doubling input of exactly 0xC0000000, where the value is exact but the flag must still set, and halfword clamps where only one of the two halves saturates.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD_WRAP  = 4'd0,
    OP_ADD_SS    = 4'd1,
    OP_SUB_SS    = 4'd2,
    OP_DBL_SS    = 4'd3,
    OP_ADD_US    = 4'd4,
    OP_SUB_US    = 4'd5,
    OP_CLAMP_S   = 4'd6,
    OP_CLAMP_S2H = 4'd7,
    OP_CLAMP_U   = 4'd8,
    OP_CLAMP_U2H = 4'd9,
    OP_ADD_SS_W  = 4'd10,
    OP_ADD_US_W  = 4'd11,
    OP_SUB_SS_W  = 4'd12,
    OP_SUB_US_W  = 4'd13
  } sat_op_e;

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] add_s,
  output logic         add_s_ovf,
  output logic [W-1:0] sub_s,
  output logic         sub_s_ovf,
  output logic [W-1:0] add_u,
  output logic         add_u_ovf,
  output logic [W-1:0] sub_u,
  output logic         sub_u_ovf
);

  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  // limit chosen by the sign of the first operand
  function automatic logic [W-1:0] f_limit(input logic [W-1:0] x);
    return x[W-1] ? S_MIN : S_MAX;
  endfunction

  function automatic logic f_add_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                     input logic [W-1:0] s);
    return (s[W-1] ^ x[W-1]) & ~(x[W-1] ^ y[W-1]);
  endfunction

  function automatic logic f_sub_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                     input logic [W-1:0] d);
    return (d[W-1] ^ x[W-1]) & (x[W-1] ^ y[W-1]);
  endfunction

  logic [W:0]   sum_ext;
  logic [W-1:0] diff;

  assign sum_ext = {1'b0, a} + {1'b0, b};
  assign diff    = a - b;

  assign add_s_ovf = f_add_ovf(a, b, sum_ext[W-1:0]);
  assign add_s     = add_s_ovf ? f_limit(a) : sum_ext[W-1:0];
  assign sub_s_ovf = f_sub_ovf(a, b, diff);
  assign sub_s     = sub_s_ovf ? f_limit(a) : diff;
  assign add_u_ovf = sum_ext[W];
  assign add_u     = add_u_ovf ? {W{1'b1}} : sum_ext[W-1:0];
  assign sub_u_ovf = (b > a);
  assign sub_u     = sub_u_ovf ? '0 : diff;

endmodule

// File: rtl/sat_lane.sv
module sat_lane #(
  parameter int unsigned LW = 32,
  parameter int unsigned SW = 5
) (
  input  logic [LW-1:0] x,
  input  logic [SW-1:0] n,
  input  logic          is_unsigned,
  output logic [LW-1:0] y,
  output logic          clamp
);

  logic [LW-1:0] top;
  logic [LW-1:0] mask;
  logic          top_pos;
  logic          top_low;

  assign top     = LW'($signed(x) >>> n);
  assign mask    = (LW'(1) << n) - LW'(1);
  assign top_pos = ~top[LW-1] & (|top);
  assign top_low = top[LW-1] & ~(&top);

  always_comb begin
    y     = x;
    clamp = 1'b0;
    if (is_unsigned) begin
      if (x[LW-1]) begin
        y     = '0;
        clamp = 1'b1;
      end else if (x > mask) begin
        y     = mask;
        clamp = 1'b1;
      end
    end else begin
      if (top_pos) begin
        y     = mask;
        clamp = 1'b1;
      end else if (top_low) begin
        y     = ~mask;
        clamp = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sat_narrow.sv
module sat_narrow #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 5
) (
  input  logic [W-1:0]  x,
  input  logic [SW-1:0] n,
  input  logic          is_unsigned,
  input  logic          dual,
  output logic [W-1:0]  y,
  output logic          clamp
);

  localparam int unsigned HW = W / 2;

  logic [W-1:0]  full_y;
  logic          full_c;
  logic [HW-1:0] half_y [2];
  logic [1:0]    half_c;

  sat_lane #(.LW(W), .SW(SW)) u_full (
    .x(x), .n(n), .is_unsigned(is_unsigned), .y(full_y), .clamp(full_c)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    sat_lane #(.LW(HW), .SW(SW)) u_half (
      .x(x[h*HW +: HW]), .n(n), .is_unsigned(is_unsigned),
      .y(half_y[h]), .clamp(half_c[h])
    );
  end

  assign y     = dual ? {half_y[1], half_y[0]} : full_y;
  assign clamp = dual ? (|half_c) : full_c;

endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [3:0]           opcode,
  input  logic [2*W-1:0]       op_a,
  input  logic [2*W-1:0]       op_b,
  input  logic [$clog2(W)-1:0] sat_n,
  input  logic                 clr_sticky,
  output logic                 out_valid,
  output logic [2*W-1:0]       result,
  output logic                 sat_flag
);

  localparam int unsigned DW = 2 * W;
  localparam logic signed [W-1:0] Q_POS = W'(1) << (W - 2);
  localparam logic signed [W-1:0] Q_NEG = -Q_POS;

  // doubling with clamp: {clamp, value}
  function automatic logic [W:0] f_double(input logic [W-1:0] v);
    if ($signed(v) >= Q_POS)      return {1'b1, 1'b0, {(W-1){1'b1}}};
    else if ($signed(v) <= Q_NEG) return {1'b1, 1'b1, {(W-1){1'b0}}};
    else                          return {1'b0, v[W-2:0], 1'b0};
  endfunction

  logic [W-1:0]  n_add_s, n_sub_s, n_add_u, n_sub_u;
  logic          n_add_s_o, n_sub_s_o, n_add_u_o, n_sub_u_o;
  logic [DW-1:0] w_add_s, w_sub_s, w_add_u, w_sub_u;
  logic          w_add_s_o, w_sub_s_o, w_add_u_o, w_sub_u_o;
  logic [W-1:0]  nar_y;
  logic          nar_c;
  logic [W:0]    dbl;
  logic [W-1:0]  wrap_sum;

  // named internal events for the checker
  logic [DW-1:0] nxt_res;
  logic          clamp_evt;
  logic          flag_set;

  sat_addsub #(.W(W)) u_as_n (
    .a(op_a[W-1:0]), .b(op_b[W-1:0]),
    .add_s(n_add_s), .add_s_ovf(n_add_s_o), .sub_s(n_sub_s), .sub_s_ovf(n_sub_s_o),
    .add_u(n_add_u), .add_u_ovf(n_add_u_o), .sub_u(n_sub_u), .sub_u_ovf(n_sub_u_o)
  );

  sat_addsub #(.W(DW)) u_as_w (
    .a(op_a), .b(op_b),
    .add_s(w_add_s), .add_s_ovf(w_add_s_o), .sub_s(w_sub_s), .sub_s_ovf(w_sub_s_o),
    .add_u(w_add_u), .add_u_ovf(w_add_u_o), .sub_u(w_sub_u), .sub_u_ovf(w_sub_u_o)
  );

  sat_narrow #(.W(W), .SW($clog2(W))) u_nar (
    .x(op_a[W-1:0]), .n(sat_n),
    .is_unsigned(opcode == OP_CLAMP_U || opcode == OP_CLAMP_U2H),
    .dual(opcode == OP_CLAMP_S2H || opcode == OP_CLAMP_U2H),
    .y(nar_y), .clamp(nar_c)
  );

  assign dbl      = f_double(op_a[W-1:0]);
  assign wrap_sum = op_a[W-1:0] + op_b[W-1:0];

  always_comb begin
    nxt_res   = '0;
    clamp_evt = 1'b0;
    case (opcode)
      OP_ADD_WRAP: begin nxt_res = DW'(wrap_sum); clamp_evt = n_add_s_o; end
      OP_ADD_SS:   begin nxt_res = DW'(n_add_s);  clamp_evt = n_add_s_o; end
      OP_SUB_SS:   begin nxt_res = DW'(n_sub_s);  clamp_evt = n_sub_s_o; end
      OP_DBL_SS:   begin nxt_res = DW'(dbl[W-1:0]); clamp_evt = dbl[W]; end
      OP_ADD_US:   begin nxt_res = DW'(n_add_u);  clamp_evt = n_add_u_o; end
      OP_SUB_US:   begin nxt_res = DW'(n_sub_u);  clamp_evt = n_sub_u_o; end
      OP_CLAMP_S, OP_CLAMP_S2H, OP_CLAMP_U, OP_CLAMP_U2H: begin
        nxt_res   = DW'(nar_y);
        clamp_evt = nar_c;
      end
      OP_ADD_SS_W: begin nxt_res = w_add_s; clamp_evt = w_add_s_o; end
      OP_ADD_US_W: begin nxt_res = w_add_u; clamp_evt = w_add_u_o; end
      OP_SUB_SS_W: begin nxt_res = w_sub_s; clamp_evt = w_sub_s_o; end
      OP_SUB_US_W: begin nxt_res = w_sub_u; clamp_evt = w_sub_u_o; end
      default: begin nxt_res = '0; clamp_evt = 1'b0; end
    endcase
  end

  assign flag_set = in_valid & clamp_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt_res;
      if (flag_set)        sat_flag <= 1'b1;
      else if (clr_sticky) sat_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk
  import sat_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [3:0]     opcode,
  input logic [2*W-1:0] op_a,
  input logic [2*W-1:0] op_b,
  input logic           clr_sticky,
  input logic           clamp_evt,
  input logic           out_valid,
  input logic [2*W-1:0] result,
  input logic           sat_flag
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R11
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));  // R11
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clamp_evt) |=> sat_flag);  // R10
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !clr_sticky) |=> sat_flag);  // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sticky && !(in_valid && clamp_evt)) |=> !sat_flag);  // R10
  AST_SADD_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_ADD_SS && !op_a[W-1] && !op_b[W-1]) |=> !result[W-1]);  // R1
  AST_USUB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_SUB_US && (op_a[W-1:0] < op_b[W-1:0])) |=> (result == '0 && sat_flag));  // R3
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode < 4'd10) |=> (result[2*W-1:W] == '0));  // R12

endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .op_a(op_a), .op_b(op_b), .clr_sticky(clr_sticky), .clamp_evt(clamp_evt),
  .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
);

// File: tb/sim_sat_alu.sv
module sim_sat_alu;

  localparam int PERIOD = 10;
  localparam int WDOG   = 100000;
  localparam int NV     = 36;

  typedef struct packed {
    logic [3:0]  op;
    logic [4:0]  n;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] r;
    logic        f;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    {4'd1, 5'd0, 64'h7FFFFFFF, 64'h1, 64'h7FFFFFFF, 1'b1},
    {4'd1, 5'd0, 64'h80000000, 64'hFFFFFFFF, 64'h80000000, 1'b1},
    {4'd1, 5'd0, 64'h5, 64'hFFFFFFFD, 64'h2, 1'b0},
    {4'd1, 5'd0, 64'hFFFF0000_00000001, 64'h12345678_00000002, 64'h3, 1'b0},
    {4'd2, 5'd0, 64'h80000000, 64'h1, 64'h80000000, 1'b1},
    {4'd2, 5'd0, 64'h7FFFFFFF, 64'hFFFFFFFF, 64'h7FFFFFFF, 1'b1},
    {4'd2, 5'd0, 64'hA, 64'h3, 64'h7, 1'b0},
    {4'd4, 5'd0, 64'hFFFFFFF0, 64'h20, 64'hFFFFFFFF, 1'b1},
    {4'd4, 5'd0, 64'h1, 64'h2, 64'h3, 1'b0},
    {4'd5, 5'd0, 64'h3, 64'h5, 64'h0, 1'b1},
    {4'd5, 5'd0, 64'h9, 64'h5, 64'h4, 1'b0},
    {4'd3, 5'd0, 64'h40000000, 64'h0, 64'h7FFFFFFF, 1'b1},
    {4'd3, 5'd0, 64'h3FFFFFFF, 64'h0, 64'h7FFFFFFE, 1'b0},
    {4'd3, 5'd0, 64'hC0000000, 64'h0, 64'h80000000, 1'b1},
    {4'd3, 5'd0, 64'hC0000001, 64'h0, 64'h80000002, 1'b0},
    {4'd6, 5'd7, 64'h100, 64'h0, 64'h7F, 1'b1},
    {4'd6, 5'd7, 64'hFFFFFF00, 64'h0, 64'hFFFFFF80, 1'b1},
    {4'd6, 5'd7, 64'h7F, 64'h0, 64'h7F, 1'b0},
    {4'd6, 5'd7, 64'hFFFFFF80, 64'h0, 64'hFFFFFF80, 1'b0},
    {4'd8, 5'd8, 64'hFFFFFFFF, 64'h0, 64'h0, 1'b1},
    {4'd8, 5'd8, 64'h100, 64'h0, 64'hFF, 1'b1},
    {4'd8, 5'd8, 64'hFF, 64'h0, 64'hFF, 1'b0},
    {4'd7, 5'd7, 64'h01000005, 64'h0, 64'h007F0005, 1'b1},
    {4'd7, 5'd7, 64'hFF800040, 64'h0, 64'hFF800040, 1'b0},
    {4'd7, 5'd7, 64'h00038000, 64'h0, 64'h0003FF80, 1'b1},
    {4'd9, 5'd4, 64'h0020FFFF, 64'h0, 64'h000F0000, 1'b1},
    {4'd9, 5'd4, 64'h0007000A, 64'h0, 64'h0007000A, 1'b0},
    {4'd0, 5'd0, 64'h7FFFFFFF, 64'h1, 64'h80000000, 1'b1},
    {4'd0, 5'd0, 64'h1, 64'h2, 64'h3, 1'b0},
    {4'd10, 5'd0, 64'h7FFFFFFF_FFFFFFFF, 64'h1, 64'h7FFFFFFF_FFFFFFFF, 1'b1},
    {4'd12, 5'd0, 64'h80000000_00000000, 64'h1, 64'h80000000_00000000, 1'b1},
    {4'd11, 5'd0, 64'hFFFFFFFF_FFFFFFFF, 64'h1, 64'hFFFFFFFF_FFFFFFFF, 1'b1},
    {4'd13, 5'd0, 64'h1, 64'h2, 64'h0, 1'b1},
    {4'd10, 5'd0, 64'h00000001_00000000, 64'hFFFFFFFF, 64'h00000001_FFFFFFFF, 1'b0},
    {4'd13, 5'd0, 64'h00000001_00000000, 64'h1, 64'hFFFFFFFF, 1'b0},
    {4'd15, 5'd0, 64'h5, 64'h6, 64'h0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  opcode;
  logic [63:0] op_a, op_b;
  logic [4:0]  sat_n;
  logic        clr_sticky;
  logic        out_valid;
  logic [63:0] result;
  logic        sat_flag;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  sat_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .sat_n(sat_n), .clr_sticky(clr_sticky),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd4, 4'd5: return "R3";
      4'd3: return "R4";
      4'd6: return "R5";
      4'd8: return "R6";
      4'd7, 4'd9: return "R7";
      4'd0: return "R8";
      4'd10, 4'd11, 4'd12, 4'd13: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one op at a falling edge; outputs are sampled one cycle later
  task automatic run_op(input logic [3:0] op, input logic [4:0] n, input logic [63:0] a,
                        input logic [63:0] b, input logic clr);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; sat_n = n; op_a = a; op_b = b; clr_sticky = clr;
    @(negedge clk);
    in_valid = 1'b0; clr_sticky = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=done", WDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; op_a = '0; op_b = '0;
    sat_n = '0; clr_sticky = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(result == 64'h0, "R11 reset result", result, 64'h0);
    chk(out_valid == 1'b0, "R11 reset valid", 64'(out_valid), 64'h0);
    chk(sat_flag == 1'b0, "R11 reset flag", 64'(sat_flag), 64'h0);

    // table walk: clear held high so each flag reflects only its own clamp (R10)
    for (int i = 0; i < NV; i++) begin
      run_op(TBL[i].op, TBL[i].n, TBL[i].a, TBL[i].b, 1'b1);
      chk(out_valid == 1'b1, "R11 valid", 64'(out_valid), 64'h1);
      chk(result == TBL[i].r, req_of(TBL[i].op), result, TBL[i].r);
      chk(sat_flag == TBL[i].f, "R10 flag", 64'(sat_flag), 64'(TBL[i].f));
    end

    // R10 stickiness
    run_op(4'd1, 5'd0, 64'h7FFFFFFF, 64'h1, 1'b0);
    chk(sat_flag == 1'b1, "R10 set", 64'(sat_flag), 64'h1);
    run_op(4'd1, 5'd0, 64'h1, 64'h2, 1'b0);
    chk(sat_flag == 1'b1, "R10 hold", 64'(sat_flag), 64'h1);
    chk(result == 64'h3, "R1 plain", result, 64'h3);
    @(negedge clk); clr_sticky = 1'b1;
    @(negedge clk); clr_sticky = 1'b0;
    chk(sat_flag == 1'b0, "R10 clear", 64'(sat_flag), 64'h0);
    chk(out_valid == 1'b0, "R11 idle valid", 64'(out_valid), 64'h0);
    chk(result == 64'h3, "R11 hold", result, 64'h3);
    run_op(4'd4, 5'd0, 64'h1, 64'h2, 1'b0);
    chk(sat_flag == 1'b0, "R10 stays clear", 64'(sat_flag), 64'h0);
    run_op(4'd14, 5'd0, 64'hFFFFFFFF, 64'hFFFFFFFF, 1'b0);
    chk(result == 64'h0, "R12 opcode 14", result, 64'h0);
    chk(sat_flag == 1'b0, "R12 no flag", 64'(sat_flag), 64'h0);
    run_op(4'd5, 5'd0, 64'h0, 64'h1, 1'b0);
    chk(sat_flag == 1'b1, "R3 floor flag", 64'(sat_flag), 64'h1);
    run_op(4'd3, 5'd0, 64'hC0000000, 64'h0, 1'b1);
    chk(sat_flag == 1'b1, "R4 exact limit with clear", 64'(sat_flag), 64'h1);

    // reset mid-run clears state (R11)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(result == 64'h0, "R11 rerun reset", result, 64'h0);
    chk(sat_flag == 1'b0, "R11 rerun flag", 64'(sat_flag), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule